// File: doc/BRIEF.md
# Fault Latch and Serial Status Responder

This block collects fault conditions for a sixteen-channel output driver and reports them to a host over a serial peripheral link. Each channel's fault input and a supply over-voltage input are level signals synchronous to the system clock. Any cycle in which one of them is high sets a sticky flag. When the host pulls chip select low, the current flags are packed into a 24-bit status word. That word is shifted out on the serial output, most significant bit first, one bit per serial clock period.

The status word has a fixed layout. The low sixteen bits carry the channel flags, and a 1 always means a fault. Bit 22 carries over-voltage and bit 23 is the OR of every flag. Bits 21 to 16 are padding and read as zero.

When chip select returns high, the flags that were reported are cleared. A fault that is still present, or one that first appeared after the word was loaded, is kept for the next frame. Frames have to be spaced far enough apart for sensing to settle. The block measures the time from one frame start to the next in system clocks, and a frame that comes too soon raises a sticky too-early flag.

The serial link is oversampled. Chip select and serial clock are registered in the system clock domain, and their edges are found by comparing each input with its registered copy. A three-state machine sequences each frame:

- ST_IDLE: no frame is in progress.
- ST_SHIFT: the word is being shifted out.
- ST_DONE: all 24 bits have gone out.

The machine has four transitions:

- IDLE to SHIFT on a chip select falling edge, which also loads the word.
- SHIFT to DONE on the serial clock falling edge that follows the 24th rising edge.
- SHIFT to IDLE on a chip select rising edge, for a frame cut short.
- DONE to IDLE on a chip select rising edge.

Top module: `fsr_status_resp`

## Requirements
- R1: On the cycle after the chip select falling edge is sampled, the serial output shows status bit 23. Each serial clock falling edge, detected one clock after the pin falls, advances the output to the next lower bit, so the host reads the word MSB first on serial clock rising edges (mode 0).
- R2: Status bits 15:0 report the latched fault flag of channels 15 to 0, with 1 meaning fault and 0 meaning no fault.
- R3: Status bits 21:16 always read as 0.
- R4: Status bit 22 reports the latched over-voltage flag, and bit 23 is 1 exactly when any of bits 22 and 15:0 is 1.
- R5: A fault input high for a single clock cycle is latched, and it is reported in the next frame that is loaded after it.
- R6: On the chip select rising edge, every flag that was reported in that frame is cleared, so a fault that has ended is not reported again in the following frame.
- R7: No fault is lost. A fault input still high when clearing happens stays flagged. A fault that first appears after the word was loaded is kept and reported in the next frame.
- R8: After all 24 bits have been shifted, the serial output is 0 until chip select rises.
- R9: While no frame is active, the serial output is high impedance when parameter IDLE_HIZ is 1, or driven 0 when IDLE_HIZ is 0.
- R10: A frame start that comes MIN_CYC = CYC_PER_US*GAP_US clock cycles or fewer after the previous frame start sets too_early. A spacing of MIN_CYC+1 or more leaves too_early unchanged, and the first frame after reset is never early.
- R11: Once set, too_early stays 1 until reset. An early frame still delivers a correct status word.
- R12: Reset clears all flags and too_early, and returns the block to idle, so the first frame reads all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, frames a transaction |
| sclk | input | 1 | Serial clock from the host, idles low |
| out_fault | input | 16 | Per-channel fault levels, 1 = fault |
| ov_fault | input | 1 | Over-voltage fault level, 1 = fault |
| so | output | 1 | Serial status output |
| too_early | output | 1 | Sticky flag: a frame started too soon after the previous one |

## Verification
The bench pulses a fault for one cycle in the middle of a frame, after the word was loaded. A design that simply cleared every flag at chip select rise would drop that fault, and the next frame would read zero. It holds a fault across several frames and then releases it. A design that failed to re-latch would lose the flag, and one that failed to clear would keep reporting it after it ended. It starts frames exactly MIN_CYC and MIN_CYC+1 cycles apart, so an off-by-one in the spacing compare would flag the wrong one, and it checks that the first frame after reset is exempt. It also sets every channel and over-voltage together to show that bits 21:16 stay zero, and it reads the output after the last bit to catch a shifter that keeps driving data.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int FRAME_BITS = 24;
    localparam int N_OUT      = 16;
    localparam int OV_POS     = 22;
    localparam int ANY_POS    = 23;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } fsr_state_e;

    // Assemble the status word from latched flags; padding bits stay zero.
    function automatic logic [FRAME_BITS-1:0] pack_status(
        input logic [N_OUT-1:0] chan,
        input logic             ov
    );
        logic [FRAME_BITS-1:0] w;
        w              = '0;
        w[N_OUT-1:0]   = chan;
        w[OV_POS]      = ov;
        w[ANY_POS]     = (|chan) | ov;
        return w;
    endfunction
endpackage

// File: rtl/fsr_edge_det.sv
module fsr_edge_det #(
    parameter int             W       = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= din;
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise[i] =  din[i] & ~prev_q[i];
        assign fall[i] = ~din[i] &  prev_q[i];
    end
endmodule

// File: rtl/fsr_fault_latch.sv
module fsr_fault_latch
    import fsr_pkg::*;
#(
    parameter int NF = N_OUT + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] live,
    input  logic          load,
    input  logic          clr,
    output logic [NF-1:0] flags
);
    logic [NF-1:0] snap_q;
    logic [NF-1:0] flags_d;

    always_comb begin
        flags_d = flags;
        if (clr) flags_d = flags & ~snap_q;
        flags_d = flags_d | live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags  <= '0;
            snap_q <= '0;
        end else begin
            flags <= flags_d;
            if (load) snap_q <= flags;
        end
    end

    AST_LIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (live != '0) |=> ((flags & $past(live)) == $past(live))); // R7
endmodule

// File: rtl/fsr_spacing_chk.sv
module fsr_spacing_chk #(
    parameter int MIN_CYC = 450
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic too_early
);
    localparam int SAT   = MIN_CYC + 1;
    localparam int GAP_W = $clog2(SAT + 1);

    logic [GAP_W-1:0] gap_q;
    logic             armed_q;
    logic             early_now;

    assign early_now = start && armed_q && (gap_q <= GAP_W'(MIN_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q     <= '0;
            armed_q   <= 1'b0;
            too_early <= 1'b0;
        end else begin
            if (start) begin
                gap_q   <= GAP_W'(1);
                armed_q <= 1'b1;
            end else if (gap_q != GAP_W'(SAT)) begin
                gap_q <= gap_q + 1'b1;
            end
            if (early_now) too_early <= 1'b1;
        end
    end

    AST_EARLY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        too_early |=> too_early); // R11
endmodule

// File: rtl/fsr_frame_ctrl.sv
module fsr_frame_ctrl
    import fsr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_fall,
    input  logic                  cs_rise,
    input  logic                  sclk_rise,
    input  logic                  sclk_fall,
    input  logic [FRAME_BITS-1:0] word_in,
    output logic                  load,
    output logic                  so_d,
    output logic                  drive
);
    fsr_state_e            state_q, state_d;
    logic [FRAME_BITS-1:0] sh_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  last_fall;

    assign last_fall = sclk_fall && (cnt_q == CNT_W'(FRAME_BITS));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall)        state_d = ST_SHIFT;
            ST_SHIFT: if (cs_rise)        state_d = ST_IDLE;
                      else if (last_fall) state_d = ST_DONE;
            ST_DONE:  if (cs_rise)        state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load  = 1'b0;
        so_d  = 1'b0;
        drive = 1'b0;
        unique case (state_q)
            ST_IDLE:  load = cs_fall;
            ST_SHIFT: begin
                drive = 1'b1;
                so_d  = sh_q[FRAME_BITS-1];
            end
            ST_DONE:  drive = 1'b1;
            default:  ;
        endcase
    end

    // Shift register and sample counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= word_in;
            cnt_q <= '0;
        end else if (state_q == ST_SHIFT) begin
            if (sclk_rise && cnt_q != CNT_W'(FRAME_BITS)) cnt_q <= cnt_q + 1'b1;
            if (sclk_fall && !last_fall) sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
        end
    end

    AST_SUMMARY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sh_q[ANY_POS] == (|sh_q[ANY_POS-1:0]))); // R4
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sh_q[OV_POS-1:N_OUT] == '0)); // R3
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> (so_d == 1'b0)); // R8
endmodule

// File: rtl/fsr_status_resp.sv
module fsr_status_resp
    import fsr_pkg::*;
#(
    parameter int CYC_PER_US = 200,
    parameter int GAP_US     = 450,
    parameter bit IDLE_HIZ   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [N_OUT-1:0] out_fault,
    input  logic             ov_fault,
    output logic             so,
    output logic             too_early
);
    localparam int MIN_CYC = CYC_PER_US * GAP_US;
    localparam int NF      = N_OUT + 1;

    logic [1:0]            rise, fall;
    logic                  load, so_d, drive;
    logic [NF-1:0]         flags;
    logic [FRAME_BITS-1:0] word;

    fsr_edge_det #(.W(2), .RST_VAL(2'b10)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sclk}),
        .rise (rise),
        .fall (fall)
    );

    fsr_fault_latch #(.NF(NF)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .live ({ov_fault, out_fault}),
        .load (load),
        .clr  (rise[1]),
        .flags(flags)
    );

    assign word = pack_status(flags[N_OUT-1:0], flags[N_OUT]);

    fsr_frame_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_fall  (fall[1]),
        .cs_rise  (rise[1]),
        .sclk_rise(rise[0]),
        .sclk_fall(fall[0]),
        .word_in  (word),
        .load     (load),
        .so_d     (so_d),
        .drive    (drive)
    );

    fsr_spacing_chk #(.MIN_CYC(MIN_CYC)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (fall[1]),
        .too_early(too_early)
    );

    generate
        if (IDLE_HIZ) begin : g_hiz
            assign so = drive ? so_d : 1'bz;
        end else begin : g_low
            assign so = drive ? so_d : 1'b0;
        end
    endgenerate
endmodule

// File: tb/fsr_status_resp_tb.sv
module fsr_status_resp_tb;
    localparam int MIN_CYC = 450;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [15:0] out_fault = '0;
    logic        ov_fault = 1'b0;
    logic        so;
    logic        too_early;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int last_start = 0;
    bit finished = 0;

    logic [23:0] exp_q[$];
    string       tag_q[$];
    logic [23:0] cap = '0;
    int          nb = 0;

    fsr_status_resp #(.CYC_PER_US(1), .GAP_US(MIN_CYC), .IDLE_HIZ(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .out_fault(out_fault), .ov_fault(ov_fault), .so(so), .too_early(too_early)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: assemble bits on host sampling edges, compare at frame end
    always @(negedge cs_n) begin
        nb  = 0;
        cap = '0;
    end
    always @(posedge sclk) begin
        if (!cs_n) begin
            cap = {cap[22:0], so};
            nb++;
        end
    end
    always @(posedge cs_n) begin
        if (nb != 0) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected frame actual %h expected none", cap);
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (nb != 24 || cap !== e) begin
                    fails++;
                    $display("FAIL %s actual %h (%0d bits) expected %h", t, cap, nb, e);
                end
            end
            nb = 0;
        end
    end

    // Driver: push expected word, run one 24-bit frame
    task automatic frame(input logic [23:0] exp, input string tag, input int pulse_bit);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cs_n = 1'b0;
        last_start = cyc;
        tick(3);
        for (int i = 0; i < 24; i++) begin
            if (i == 1 && pulse_bit >= 0) begin
                out_fault[pulse_bit] = 1'b1;
                tick(1);
                out_fault[pulse_bit] = 1'b0;
            end
            sclk = 1'b1;
            tick(2);
            sclk = 1'b0;
            tick(2);
        end
        check1("R8 output after last bit", so, 1'b0);
        cs_n = 1'b1;
        tick(2);
        check1("R9 idle output low", so, 1'b0);
    endtask

    task automatic wait_gap(input int g);
        while (cyc - last_start < g) tick(1);
    endtask

    task automatic pulse(input int b);
        out_fault[b] = 1'b1;
        tick(1);
        out_fault[b] = 1'b0;
        tick(1);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        check1("R12 reset so", so, 1'b0);
        check1("R12 reset too_early", too_early, 1'b0);

        frame(24'h000000, "R12 first frame all zero", -1);
        check1("R10 first frame exempt", too_early, 1'b0);

        pulse(3);
        wait_gap(500);
        frame(24'h800008, "R5 R2 one-cycle pulse ch3", -1);
        wait_gap(500);
        frame(24'h000000, "R6 cleared after report", -1);

        out_fault[15] = 1'b1;
        wait_gap(500);
        frame(24'h808000, "R2 R7 held ch15 first", -1);
        wait_gap(500);
        frame(24'h808000, "R7 held ch15 relatched", -1);
        out_fault[15] = 1'b0;
        wait_gap(500);
        frame(24'h808000, "R5 ch15 latched after release", -1);
        wait_gap(500);
        frame(24'h000000, "R6 ch15 gone", -1);

        ov_fault = 1'b1;
        tick(1);
        ov_fault = 1'b0;
        wait_gap(500);
        frame(24'hC00000, "R4 over-voltage bit", -1);

        wait_gap(500);
        frame(24'h000000, "R7 pulse after load not in frame", 5);
        wait_gap(500);
        frame(24'h800020, "R7 pulse after load kept", -1);

        out_fault = 16'hFFFF;
        ov_fault  = 1'b1;
        wait_gap(500);
        frame(24'hC0FFFF, "R3 R4 all faults pad zero", -1);
        out_fault = 16'h0;
        ov_fault  = 1'b0;
        wait_gap(500);
        frame(24'hC0FFFF, "R1 all faults latched", -1);

        wait_gap(MIN_CYC + 1);
        frame(24'h000000, "R6 spacing ok frame", -1);
        check1("R10 spacing MIN_CYC+1 not early", too_early, 1'b0);

        pulse(0);
        wait_gap(MIN_CYC);
        frame(24'h800001, "R11 early frame still valid", -1);
        check1("R10 spacing MIN_CYC early", too_early, 1'b1);

        wait_gap(600);
        frame(24'h000000, "R6 after early frame", -1);
        check1("R11 too_early sticky", too_early, 1'b1);

        tick(4);
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1 frames missing actual %0d expected 0", exp_q.size());
        end
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule